// File: doc/BRIEF.md
# PLL Rate Reprogramming Sequencer

This block changes the output rate of a PLL by updating its control registers over a simple register bus. A request gives a post-divide ratio (1, 2, 4 or 8) and a feedback divider control word. The block then updates the post-divider field and the control-word field in place. For each field it reads the register, replaces only that field and writes the register back. All other bits are left as they were.

Before the divider words are applied, the block reads the PLL's base-enable flag. After the feedback word is written, the block rewrites the second control register. If the PLL is running, it sets the change-request bit in that register. When a tuner register is present, the block writes it with the same value plus one. If the PLL was running, the block then stays busy for a fixed settle window before it reports completion. If the PLL was idle, it reports completion at once. A ratio that cannot be encoded is rejected with a one-cycle error pulse, and no bus access is made.

The register bus has a read latency of one cycle. Read data is valid in the cycle after the read strobe. At most one strobe is active in any cycle.

Top module: `pllrp_seq`

## Requirements
- R1: A ratio of 1, 2, 4 or 8 is stored as the 3-bit code 0, 1, 2 or 3 in bits [PD_SHIFT+2:PD_SHIFT] of the post-divider register.
- R2: The post-divider write keeps every bit outside that 3-bit field at the value just read.
- R3: The control word occupies bits [PCW_SHIFT+PCW_BITS-1:PCW_SHIFT] of its register, and all other bits of that register keep the value just read.
- R4: An accepted request produces exactly this bus sequence: read post-divider, write post-divider, read control-0, read control-word register, write control-word register, read control-1, write control-1, then (when HAS_TUNER=1) write tuner.
- R5: Bit 0 of control-0 is the enable flag. When it reads 1, control-1 is written with bit 31 set. When it reads 0, control-1 is written back unchanged.
- R6: With HAS_TUNER=1, the tuner register is written with the control-1 value just written, plus one (modulo 2^32).
- R7: When enabled, `done` comes SETTLE_CYCLES+1 cycles after the last write, and `busy` stays high throughout.
- R8: When not enabled, `done` comes in the cycle right after the last write. `done` lasts one cycle and `busy` falls after it.
- R9: A ratio of 0, a ratio that is not a power of two, or a ratio above 8 raises `err` for one cycle, the cycle after the request. It causes no bus access and leaves `busy` low.
- R10: A request presented while `busy` is high is ignored and changes no register.
- R11: After `done`, the block makes no further bus access. Bit 31 of control-1 therefore stays as written.
- R12: After reset, `busy`, `done`, `err`, `bus_rd` and `bus_wr` are low. `bus_rd` and `bus_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_ratio | input | RATIO_W | Post-divide ratio |
| req_pcw | input | PCW_BITS | Feedback divider control word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected ratio |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid one cycle after `bus_rd` |

## Verification
The assertions assume the bus returns read data exactly one cycle after the read strobe. They also assume the register addresses are distinct, so the data in a write cycle is the value read for the same register. The bench bus model follows that latency exactly and uses distinct addresses.

The bench varies the stored enable flag, the ratio and the background bit patterns across runs. It also raises a second request during the settle window, to show that requests arriving while busy are ignored.

// File: rtl/pllrp_pkg.sv
package pllrp_pkg;
    localparam int WORD_W  = 32;
    localparam int EN_BIT  = 0;
    localparam int CHG_BIT = 31;
    localparam int PD_W    = 3;
    localparam int MAX_LOG = 3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_PD,
        S_WR_PD,
        S_RD_EN,
        S_RD_PCW,
        S_WR_PCW,
        S_RD_C1,
        S_WR_C1,
        S_WR_TUN,
        S_WAIT,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/pllrp_ratio_dec.sv
module pllrp_ratio_dec #(
    parameter int RATIO_W = 5,
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 3
) (
    input  logic [RATIO_W-1:0] ratio,
    output logic [CODE_W-1:0]  code,
    output logic               ok
);
    always_comb begin
        code = '0;
        ok   = 1'b0;
        for (int i = 0; i <= MAX_LOG; i++) begin
            if (ratio == RATIO_W'(64'd1 << i)) begin
                code = CODE_W'(i);
                ok   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pllrp_field_merge.sv
module pllrp_field_merge #(
    parameter int DATA_W = 32,
    parameter int SHIFT  = 0,
    parameter int WIDTH  = 3
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [WIDTH-1:0]  field,
    output logic [DATA_W-1:0] word_out
);
    localparam logic [DATA_W-1:0] MASK = DATA_W'(((64'd1 << WIDTH) - 64'd1) << SHIFT);

    logic [DATA_W-1:0] placed;

    always_comb begin
        placed   = DATA_W'(field) << SHIFT;
        word_out = (word_in & ~MASK) | (placed & MASK);
    end
endmodule

// File: rtl/pllrp_settle_timer.sv
module pllrp_settle_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pllrp_seq.sv
module pllrp_seq
    import pllrp_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter int                RATIO_W       = 5,
    parameter int                PCW_BITS      = 21,
    parameter int                PCW_SHIFT     = 2,
    parameter int                PD_SHIFT      = 24,
    parameter logic [ADDR_W-1:0] CON0_ADDR     = 'h00,
    parameter logic [ADDR_W-1:0] CON1_ADDR     = 'h04,
    parameter logic [ADDR_W-1:0] PD_ADDR       = 'h0C,
    parameter logic [ADDR_W-1:0] PCW_ADDR      = 'h10,
    parameter logic [ADDR_W-1:0] TUNER_ADDR    = 'h14,
    parameter bit                HAS_TUNER     = 1'b1,
    parameter int                SETTLE_CYCLES = 2000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [RATIO_W-1:0]  req_ratio,
    input  logic [PCW_BITS-1:0] req_pcw,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [WORD_W-1:0]   bus_wdata,
    input  logic [WORD_W-1:0]   bus_rdata
);
    localparam logic [WORD_W-1:0] PD_MASK  = WORD_W'(((64'd1 << PD_W) - 64'd1) << PD_SHIFT);
    localparam logic [WORD_W-1:0] PCW_MASK = WORD_W'(((64'd1 << PCW_BITS) - 64'd1) << PCW_SHIFT);
    localparam logic [WORD_W-1:0] CHG_FLAG = WORD_W'(64'd1 << CHG_BIT);

    typedef struct packed {
        seq_state_e          state;
        logic [PD_W-1:0]     code;
        logic [PCW_BITS-1:0] pcw;
        logic                en;
        logic [WORD_W-1:0]   con1;
        logic                err;
    } seq_t;

    seq_t s_d, s_q;

    logic [PD_W-1:0]   dec_code;
    logic              dec_ok;
    logic [WORD_W-1:0] pd_word;
    logic [WORD_W-1:0] pcw_word;
    logic              tmr_load;
    logic              tmr_zero;
    logic              wrap_up;
    logic [WORD_W-1:0] c1_word;

    pllrp_ratio_dec #(
        .RATIO_W (RATIO_W),
        .CODE_W  (PD_W),
        .MAX_LOG (MAX_LOG)
    ) u_dec (
        .ratio (req_ratio),
        .code  (dec_code),
        .ok    (dec_ok)
    );

    pllrp_field_merge #(
        .DATA_W (WORD_W),
        .SHIFT  (PD_SHIFT),
        .WIDTH  (PD_W)
    ) u_pd_merge (
        .word_in  (bus_rdata),
        .field    (s_q.code),
        .word_out (pd_word)
    );

    pllrp_field_merge #(
        .DATA_W (WORD_W),
        .SHIFT  (PCW_SHIFT),
        .WIDTH  (PCW_BITS)
    ) u_pcw_merge (
        .word_in  (bus_rdata),
        .field    (s_q.pcw),
        .word_out (pcw_word)
    );

    pllrp_settle_timer #(
        .CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .zero  (tmr_zero)
    );

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        tmr_load  = 1'b0;
        wrap_up   = 1'b0;
        c1_word   = bus_rdata | (s_q.en ? CHG_FLAG : '0);

        case (s_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    if (dec_ok) begin
                        s_d.code  = dec_code;
                        s_d.pcw   = req_pcw;
                        s_d.state = S_RD_PD;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            S_RD_PD: begin
                bus_rd    = 1'b1;
                bus_addr  = PD_ADDR;
                s_d.state = S_WR_PD;
            end
            S_WR_PD: begin
                bus_wr    = 1'b1;
                bus_addr  = PD_ADDR;
                bus_wdata = pd_word;
                s_d.state = S_RD_EN;
            end
            S_RD_EN: begin
                bus_rd    = 1'b1;
                bus_addr  = CON0_ADDR;
                s_d.state = S_RD_PCW;
            end
            S_RD_PCW: begin
                s_d.en    = bus_rdata[EN_BIT];
                bus_rd    = 1'b1;
                bus_addr  = PCW_ADDR;
                s_d.state = S_WR_PCW;
            end
            S_WR_PCW: begin
                bus_wr    = 1'b1;
                bus_addr  = PCW_ADDR;
                bus_wdata = pcw_word;
                s_d.state = S_RD_C1;
            end
            S_RD_C1: begin
                bus_rd    = 1'b1;
                bus_addr  = CON1_ADDR;
                s_d.state = S_WR_C1;
            end
            S_WR_C1: begin
                bus_wr    = 1'b1;
                bus_addr  = CON1_ADDR;
                bus_wdata = c1_word;
                s_d.con1  = c1_word;
                if (HAS_TUNER) begin
                    s_d.state = S_WR_TUN;
                end else begin
                    wrap_up = 1'b1;
                end
            end
            S_WR_TUN: begin
                bus_wr    = 1'b1;
                bus_addr  = TUNER_ADDR;
                bus_wdata = s_q.con1 + 1'b1;
                wrap_up   = 1'b1;
            end
            S_WAIT: begin
                if (tmr_zero) begin
                    s_d.state = S_DONE;
                end
            end
            S_DONE: begin
                s_d.state = S_IDLE;
            end
            default: begin
                s_d.state = S_IDLE;
            end
        endcase

        if (wrap_up) begin
            if (s_q.en) begin
                tmr_load  = 1'b1;
                s_d.state = S_WAIT;
            end else begin
                s_d.state = S_DONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: S_IDLE, code: '0, pcw: '0, en: 1'b0, con1: '0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.state != S_IDLE);
    assign done = (s_q.state == S_DONE);
    assign err  = s_q.err;
endmodule

// File: rtl/pllrp_seq_chk.sv
module pllrp_seq_chk #(
    parameter logic [31:0] PD_MASK  = '0,
    parameter logic [31:0] PCW_MASK = '0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        in_wr_pd,
    input logic        in_wr_pcw,
    input logic        in_wait,
    input logic        pll_en
);
    // R12
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R2
    pd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wr_pd |-> (((bus_wdata ^ bus_rdata) & ~PD_MASK) == 32'd0));

    // R3
    pcw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wr_pcw |-> (((bus_wdata ^ bus_rdata) & ~PCW_MASK) == 32'd0));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !bus_rd && !bus_wr));

    // R7
    wait_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> pll_en);

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

bind pllrp_seq pllrp_seq_chk #(
    .PD_MASK  (PD_MASK),
    .PCW_MASK (PCW_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .in_wr_pd  (s_q.state == pllrp_pkg::S_WR_PD),
    .in_wr_pcw (s_q.state == pllrp_pkg::S_WR_PCW),
    .in_wait   (s_q.state == pllrp_pkg::S_WAIT),
    .pll_en    (s_q.en)
);

// File: tb/tb_pllrp_seq.sv
module tb_pllrp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 12;
    localparam int RW         = 5;
    localparam int PB         = 21;
    localparam int PS         = 2;
    localparam int DS         = 24;
    localparam logic [7:0] A_C0  = 8'h00;
    localparam logic [7:0] A_C1  = 8'h04;
    localparam logic [7:0] A_PD  = 8'h0C;
    localparam logic [7:0] A_PCW = 8'h10;
    localparam logic [7:0] A_TUN = 8'h14;
    localparam logic [31:0] PDM  = 32'h0700_0000;
    localparam logic [31:0] PCWM = 32'h007F_FFFC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [RW-1:0] req_ratio = '0;
    logic [PB-1:0] req_pcw = '0;
    logic          busy, done, err, bus_rd, bus_wr;
    logic [7:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;

    logic          poke_en = 1'b0;
    logic [7:0]    poke_addr = '0;
    logic [31:0]   poke_data = '0;

    logic [31:0]   mem [0:7];
    logic          log_wr   [0:255];
    logic [7:0]    log_addr [0:255];
    logic [31:0]   log_data [0:255];
    int            op_n = 0;
    int            cyc = 0;
    int            last_wr_cyc = 0;
    int            done_cyc = 0;

    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pllrp_seq #(
        .ADDR_W(8), .RATIO_W(RW), .PCW_BITS(PB), .PCW_SHIFT(PS), .PD_SHIFT(DS),
        .CON0_ADDR(A_C0), .CON1_ADDR(A_C1), .PD_ADDR(A_PD), .PCW_ADDR(A_PCW),
        .TUNER_ADDR(A_TUN), .HAS_TUNER(1'b1), .SETTLE_CYCLES(SETTLE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ratio(req_ratio),
        .req_pcw(req_pcw), .busy(busy), .done(done), .err(err),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (poke_en) mem[poke_addr[4:2]] <= poke_data;
        if (bus_rd) bus_rdata <= mem[bus_addr[4:2]];
        if (bus_wr) begin
            mem[bus_addr[4:2]] <= bus_wdata;
            last_wr_cyc <= cyc;
        end
        if (done) done_cyc <= cyc;
        if ((bus_rd || bus_wr) && op_n < 256) begin
            log_wr[op_n]   <= bus_wr;
            log_addr[op_n] <= bus_addr;
            log_data[op_n] <= bus_wdata;
            op_n <= op_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic pulse_req(input logic [RW-1:0] r, input logic [PB-1:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_ratio = r; req_pcw = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 400 && !got; i++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
        @(negedge clk);
    endtask

    // full accepted run, checks sequence, contents and timing
    task automatic run_ok(input string tag, input logic [RW-1:0] ratio, input logic [2:0] code,
                          input logic [PB-1:0] pcw, input logic [31:0] pd_old,
                          input logic [31:0] pcw_old, input logic [31:0] c0,
                          input logic [31:0] c1_old);
        int base;
        bit got;
        logic [31:0] e_pd, e_pcw, e_c1, e_tun;
        logic        e_w [0:7];
        logic [7:0]  e_a [0:7];
        logic [31:0] e_d [0:7];
        poke(A_PD, pd_old);
        poke(A_PCW, pcw_old);
        poke(A_C0, c0);
        poke(A_C1, c1_old);
        base = op_n;
        e_pd  = (pd_old & ~PDM) | ({29'd0, code} << DS);
        e_pcw = (pcw_old & ~PCWM) | ({11'd0, pcw} << PS);
        e_c1  = c1_old | (c0[0] ? 32'h8000_0000 : 32'h0);
        e_tun = e_c1 + 32'd1;
        e_w = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
        e_a = '{A_PD, A_PD, A_C0, A_PCW, A_PCW, A_C1, A_C1, A_TUN};
        e_d = '{32'h0, e_pd, 32'h0, 32'h0, e_pcw, 32'h0, e_c1, e_tun};
        pulse_req(ratio, pcw);
        chk(busy == 1'b1, {tag, " R4 busy after accept"}, {31'd0, busy}, 32'd1);
        wait_done(got);
        chk(got, {tag, " R7/R8 done seen"}, {31'd0, got}, 32'd1);
        chk(op_n - base == 8, {tag, " R4 access count"}, op_n - base, 32'd8);
        for (int k = 0; k < 8; k++) begin
            chk(log_wr[base+k] == e_w[k] && log_addr[base+k] == e_a[k],
                {tag, " R4 access order"}, {23'd0, log_wr[base+k], log_addr[base+k]},
                {23'd0, e_w[k], e_a[k]});
            if (e_w[k])
                chk(log_data[base+k] == e_d[k], {tag, " R1/R2/R3/R5/R6 write data"},
                    log_data[base+k], e_d[k]);
        end
        chk(((mem[A_PD[4:2]] >> DS) & 32'h7) == {29'd0, code}, {tag, " R1 post-div code"},
            (mem[A_PD[4:2]] >> DS) & 32'h7, {29'd0, code});
        chk(mem[A_C1[4:2]][31] == c0[0], {tag, " R5 change bit"},
            {31'd0, mem[A_C1[4:2]][31]}, {31'd0, c0[0]});
        chk(mem[A_TUN[4:2]] == e_tun, {tag, " R6 tuner"}, mem[A_TUN[4:2]], e_tun);
        if (c0[0])
            chk(done_cyc - last_wr_cyc == SETTLE + 1, {tag, " R7 settle delay"},
                done_cyc - last_wr_cyc, SETTLE + 1);
        else
            chk(done_cyc - last_wr_cyc == 1, {tag, " R8 immediate done"},
                done_cyc - last_wr_cyc, 32'd1);
        chk(busy == 1'b0, {tag, " R8 busy released"}, {31'd0, busy}, 32'd0);
    endtask

    task automatic test_reset();
        chk(!busy && !done && !err && !bus_rd && !bus_wr, "R12 reset outputs",
            {27'd0, busy, done, err, bus_rd, bus_wr}, 32'd0);
    endtask

    task automatic test_bad(input logic [RW-1:0] r);
        int base;
        bit seen;
        base = op_n;
        @(negedge clk);
        req_valid = 1'b1; req_ratio = r; req_pcw = 21'h1ABCD;
        @(negedge clk);
        req_valid = 1'b0;
        seen = err;
        chk(seen, "R9 err pulse", {31'd0, seen}, 32'd1);
        chk(!busy, "R9 busy low", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(!err, "R9 err one cycle", {31'd0, err}, 32'd0);
        repeat (4) @(negedge clk);
        chk(op_n == base, "R9 no bus access", op_n - base, 32'd0);
    endtask

    task automatic test_busy_ignored();
        int base;
        bit got;
        logic [31:0] e_pcw;
        poke(A_C0, 32'h1);
        poke(A_PCW, 32'h0);
        base = op_n;
        e_pcw = {11'd0, 21'h00055} << PS;
        pulse_req(5'd2, 21'h00055);
        repeat (11) @(negedge clk);
        chk(busy, "R10 in settle window", {31'd0, busy}, 32'd1);
        pulse_req(5'd4, 21'h1FFFF);
        wait_done(got);
        chk(got, "R10 first run completes", {31'd0, got}, 32'd1);
        repeat (20) @(negedge clk);
        chk(op_n - base == 8, "R10 no second sequence", op_n - base, 32'd8);
        chk(mem[A_PCW[4:2]] == e_pcw, "R10 pcw unchanged", mem[A_PCW[4:2]], e_pcw);
        chk(!busy, "R10 stays idle", {31'd0, busy}, 32'd0);
    endtask

    task automatic test_no_clear();
        int base;
        base = op_n;
        repeat (30) @(negedge clk);
        chk(op_n == base, "R11 no later access", op_n - base, 32'd0);
        chk(mem[A_C1[4:2]][31] == 1'b1, "R11 change bit kept",
            {31'd0, mem[A_C1[4:2]][31]}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = '0;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_ok("disabled r1", 5'd1, 3'd0, 21'h12345, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
               32'h0000_0002, 32'h0000_1234);
        run_ok("enabled r8", 5'd8, 3'd3, 21'h1FFFFF, 32'h0000_0000, 32'h0000_0000,
               32'h0000_0001, 32'h0000_00F0);
        run_ok("disabled r2", 5'd2, 3'd1, 21'h0AAAA, 32'hA5A5_A5A5, 32'h5A5A_5A5A,
               32'hFFFF_FFFE, 32'h7FFF_FFFF);
        run_ok("enabled r4", 5'd4, 3'd2, 21'h00001, 32'h0312_3456, 32'h8000_0003,
               32'h0000_0003, 32'hFFFF_FFFF);
        test_bad(5'd0);
        test_bad(5'd3);
        test_bad(5'd16);
        test_busy_ignored();
        test_no_clear();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule